// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column address of every beat of a synchronous DRAM read or write burst. A controller gives it one start pulse together with the first column and a read/write flag. From the next clock on, the block presents one column per cycle with a valid flag, and marks the final beat with a last flag. The mode settings are held on static inputs:

- a three-bit burst-length code,
- a burst-order bit,
- a single-location write bit,
- a three-bit read-latency code.

The block checks these settings for reserved encodings and reports any it finds on an error output.

Fixed bursts of 1, 2, 4 or 8 beats stay inside the aligned block of that size. They visit it either in wrapping ascending order or in XOR order. A full-page burst walks the whole column range with wrap-around until an external stop input ends it. When the single-location write bit is set, writes collapse to one beat and reads keep their programmed length. The block does not issue commands, track banks, align data to the latency, or touch the data bus.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, `beat_valid` and `beat_last` are low and stay low until a start is accepted.
- R2: A start taken while idle presents `start_col` with `beat_valid` high in the cycle after the start edge. Each following beat comes one clock later, with no gaps, and `beat_last` is high only on a valid beat.
- R3: Burst-length codes 000, 001, 010 and 011 give bursts of exactly 1, 2, 4 and 8 beats. `beat_last` is high on the final beat.
- R4: With the order bit 0 (ascending), beat k has its low log2(L) bits equal to (start low bits + k) mod L. The upper bits equal those of `start_col`.
- R5: With the order bit 1 (XOR order), beat k has its low log2(L) bits equal to the start low bits XOR k. The upper bits equal those of `start_col`.
- R6: Code 111 with the order bit 0 is a full-page burst. Beat k is (`start_col` + k) mod 2^COL_W. The burst runs until `stop` is sampled high at a clock edge, and the beat launched by that edge carries `beat_last`.
- R7: Codes 100, 101 and 110 with either order, and code 111 with the order bit 1, are reserved. While such a code is applied, `cfg_err` is high, and a start produces a single beat.
- R8: With `wr_single` = 1, a write start gives one beat whatever the length code. Reads keep the programmed length. With `wr_single` = 0, writes also keep it.
- R9: Only latency codes 010 and 011 are legal. Any other latency code drives `cfg_err` high.
- R10: A start during an unfinished burst is ignored, and the running beats are unchanged. `stop` has no effect on a fixed-length burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bl_code | input | 3 | Burst-length code |
| burst_ilv | input | 1 | Beat order: 0 ascending wrap, 1 XOR |
| wr_single | input | 1 | Writes touch only the addressed column |
| lat_code | input | 3 | Read-latency code (checked only) |
| start | input | 1 | Start pulse for a burst |
| start_col | input | COL_W | First column of the burst |
| is_write | input | 1 | 1 for a write burst, 0 for a read |
| stop | input | 1 | Ends a full-page burst |
| col_addr | output | COL_W | Column of the current beat |
| beat_valid | output | 1 | A beat is presented |
| beat_last | output | 1 | The presented beat is the final one |
| cfg_err | output | 1 | A reserved mode code is applied |

## Verification
The first beat is due one clock after the start edge, and beat k is due k clocks after it. A full-page burst ends on the beat launched by the edge that samples `stop`. The driver computes each beat's column and last flag from the mode rules and queues them. A monitor compares each beat on the falling edge, when the registered outputs have settled, so missing, extra and misordered beats all show up. `cfg_err` is combinational, so it is checked one time step after its inputs change, with no clock involved.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

  // Width of the mode codes on the configuration inputs.
  localparam int unsigned CODE_W = 3;

  // Burst-length encodings with a defined meaning.
  localparam logic [CODE_W-1:0] BL_ONE   = 3'b000;
  localparam logic [CODE_W-1:0] BL_TWO   = 3'b001;
  localparam logic [CODE_W-1:0] BL_FOUR  = 3'b010;
  localparam logic [CODE_W-1:0] BL_EIGHT = 3'b011;
  localparam logic [CODE_W-1:0] BL_PAGE  = 3'b111;

  // The only legal latency encodings.
  localparam logic [CODE_W-1:0] LAT_TWO   = 3'b010;
  localparam logic [CODE_W-1:0] LAT_THREE = 3'b011;

  typedef enum logic [1:0] {
    LEN_FIXED = 2'd0,
    LEN_PAGE  = 2'd1,
    LEN_BAD   = 2'd2
  } len_kind_e;

endpackage

// File: rtl/burst_mode_decode.sv
module burst_mode_decode
  import bcg_pkg::*;
#(
  parameter int unsigned COL_W = 9
) (
  input  logic [CODE_W-1:0] bl_code,
  input  logic              burst_ilv,
  input  logic              wr_single,
  input  logic              is_write,
  input  logic [CODE_W-1:0] lat_code,
  output logic [COL_W-1:0]  beat_mask,
  output logic              page_mode,
  output logic              bl_bad,
  output logic              cfg_err
);

  len_kind_e        kind;
  logic [COL_W-1:0] raw_mask;
  logic             lat_bad;
  logic             force_one;

  // Classify the burst-length code and derive the wrap mask (length - 1).
  always_comb begin
    kind     = LEN_FIXED;
    raw_mask = '0;
    unique case (bl_code)
      BL_ONE:   raw_mask = COL_W'(0);
      BL_TWO:   raw_mask = COL_W'(1);
      BL_FOUR:  raw_mask = COL_W'(3);
      BL_EIGHT: raw_mask = COL_W'(7);
      BL_PAGE: begin
        if (burst_ilv) begin
          kind = LEN_BAD;
        end else begin
          kind     = LEN_PAGE;
          raw_mask = '1;
        end
      end
      default:  kind = LEN_BAD;
    endcase
  end

  assign lat_bad   = (lat_code != LAT_TWO) && (lat_code != LAT_THREE);
  assign bl_bad    = (kind == LEN_BAD);
  assign force_one = bl_bad || (wr_single && is_write);

  assign beat_mask = force_one ? '0 : raw_mask;
  assign page_mode = (kind == LEN_PAGE) && !force_one;
  assign cfg_err   = bl_bad || lat_bad;

endmodule

// File: rtl/burst_beat_addr.sv
module burst_beat_addr #(
  parameter int unsigned COL_W = 9
) (
  input  logic [COL_W-1:0] base_col,
  input  logic [COL_W-1:0] beat_idx,
  input  logic [COL_W-1:0] wrap_mask,
  input  logic             xor_order,
  output logic [COL_W-1:0] beat_col
);

  logic [COL_W-1:0] low_asc;
  logic [COL_W-1:0] low_xor;
  logic [COL_W-1:0] low_sel;

  // Ascending order adds within the aligned block. XOR order flips the low bits.
  assign low_asc  = (base_col + beat_idx) & wrap_mask;
  assign low_xor  = (base_col ^ beat_idx) & wrap_mask;
  assign low_sel  = xor_order ? low_xor : low_asc;
  assign beat_col = (base_col & ~wrap_mask) | low_sel;

endmodule

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl #(
  parameter int unsigned COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [COL_W-1:0] mask_in,
  input  logic             ilv_in,
  input  logic             page_in,
  input  logic             stop,
  output logic [COL_W-1:0] col_q,
  output logic             valid_q,
  output logic             last_q
);

  logic [COL_W-1:0] base_q, base_n;
  logic [COL_W-1:0] mask_q, mask_n;
  logic [COL_W-1:0] cnt_q, cnt_n;
  logic [COL_W-1:0] col_n;
  logic             ilv_q, ilv_n;
  logic             page_q, page_n;
  logic             valid_n, last_n;
  logic [COL_W-1:0] step_col;
  logic             busy, ld_en, adv_en, out_en;

  burst_beat_addr #(.COL_W(COL_W)) u_addr (
    .base_col  (base_q),
    .beat_idx  (cnt_q),
    .wrap_mask (mask_q),
    .xor_order (ilv_q),
    .beat_col  (step_col)
  );

  assign busy   = valid_q && !last_q;
  assign ld_en  = start && !busy;
  assign adv_en = busy;
  assign out_en = ld_en || adv_en || valid_q;

  // Next-state logic.
  always_comb begin
    base_n  = base_q;
    mask_n  = mask_q;
    ilv_n   = ilv_q;
    page_n  = page_q;
    cnt_n   = cnt_q;
    col_n   = col_q;
    valid_n = 1'b0;
    last_n  = 1'b0;
    if (ld_en) begin
      base_n  = start_col;
      mask_n  = mask_in;
      ilv_n   = ilv_in;
      page_n  = page_in;
      cnt_n   = COL_W'(1);
      col_n   = start_col;
      valid_n = 1'b1;
      last_n  = (mask_in == '0) && !page_in;
    end else if (adv_en) begin
      cnt_n   = cnt_q + COL_W'(1);
      col_n   = step_col;
      valid_n = 1'b1;
      last_n  = page_q ? stop : (cnt_q == mask_q);
    end
  end

  // State registers with explicit enables.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      mask_q  <= '0;
      ilv_q   <= 1'b0;
      page_q  <= 1'b0;
      cnt_q   <= '0;
      col_q   <= '0;
      valid_q <= 1'b0;
      last_q  <= 1'b0;
    end else begin
      if (ld_en) begin
        base_q <= base_n;
        mask_q <= mask_n;
        ilv_q  <= ilv_n;
        page_q <= page_n;
      end
      if (ld_en || adv_en) begin
        cnt_q <= cnt_n;
        col_q <= col_n;
      end
      if (out_en) begin
        valid_q <= valid_n;
        last_q  <= last_n;
      end
    end
  end

  AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    last_q |-> valid_q); // R2
  AST_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !last_q) |=> valid_q); // R2
  AST_ASC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !last_q && !ilv_q) |=>
      ((((col_q - $past(col_q)) & mask_q) == COL_W'(1)) &&
       ((col_q & ~mask_q) == ($past(col_q) & ~mask_q)))); // R4
  AST_XOR_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !last_q && ilv_q) |=>
      (((col_q & ~mask_q) == (base_q & ~mask_q)) && (col_q != $past(col_q)))); // R5
  AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !last_q && page_q && stop) |=> (valid_q && last_q)); // R6
  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !last_q && start) |=> $stable(base_q)); // R10

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import bcg_pkg::*;
#(
  parameter int unsigned COL_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] bl_code,
  input  logic              burst_ilv,
  input  logic              wr_single,
  input  logic [CODE_W-1:0] lat_code,
  input  logic              start,
  input  logic [COL_W-1:0]  start_col,
  input  logic              is_write,
  input  logic              stop,
  output logic [COL_W-1:0]  col_addr,
  output logic              beat_valid,
  output logic              beat_last,
  output logic              cfg_err
);

  logic [COL_W-1:0] mask_w;
  logic             page_w;
  logic             bl_bad_w;

  burst_mode_decode #(.COL_W(COL_W)) u_dec (
    .bl_code   (bl_code),
    .burst_ilv (burst_ilv),
    .wr_single (wr_single),
    .is_write  (is_write),
    .lat_code  (lat_code),
    .beat_mask (mask_w),
    .page_mode (page_w),
    .bl_bad    (bl_bad_w),
    .cfg_err   (cfg_err)
  );

  burst_seq_ctrl #(.COL_W(COL_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .start_col (start_col),
    .mask_in   (mask_w),
    .ilv_in    (burst_ilv),
    .page_in   (page_w),
    .stop      (stop),
    .col_q     (col_addr),
    .valid_q   (beat_valid),
    .last_q    (beat_last)
  );

  AST_RESERVED_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !(beat_valid && !beat_last) && bl_bad_w) |=> (beat_valid && beat_last)); // R7
  AST_WRITE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !(beat_valid && !beat_last) && wr_single && is_write)
      |=> (beat_valid && beat_last && (col_addr == $past(start_col)))); // R8

endmodule

// File: tb/burst_col_gen_tb.sv
module burst_col_gen_tb_top;

  localparam int unsigned COL_W = 9;
  localparam int unsigned PAGE  = 1 << COL_W;

  logic             clk;
  logic             rst_n;
  logic [2:0]       bl_code;
  logic             burst_ilv;
  logic             wr_single;
  logic [2:0]       lat_code;
  logic             start;
  logic [COL_W-1:0] start_col;
  logic             is_write;
  logic             stop;
  logic [COL_W-1:0] col_addr;
  logic             beat_valid;
  logic             beat_last;
  logic             cfg_err;

  int n_cmp = 0;
  int n_bad = 0;

  logic [COL_W-1:0] q_col[$];
  logic             q_last[$];
  string            q_tag[$];

  burst_col_gen #(.COL_W(COL_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .bl_code(bl_code), .burst_ilv(burst_ilv),
    .wr_single(wr_single), .lat_code(lat_code), .start(start),
    .start_col(start_col), .is_write(is_write), .stop(stop),
    .col_addr(col_addr), .beat_valid(beat_valid), .beat_last(beat_last),
    .cfg_err(cfg_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [COL_W-1:0] exp_col(int base, int len, bit ilv, bit page, int k);
    int lo, hi;
    if (page) return COL_W'((base + k) % PAGE);
    lo = base % len;
    hi = base - lo;
    if (ilv) return COL_W'(hi + (lo ^ k));
    return COL_W'(hi + ((lo + k) % len));
  endfunction

  // Monitor: compare each presented beat against the queue head.
  always @(negedge clk) begin
    if (rst_n && beat_valid) begin
      n_cmp++;
      if (q_col.size() == 0) begin
        n_bad++;
        $display("FAIL unexpected beat (R2/R10): actual col=%0d last=%0b expected none",
                 col_addr, beat_last);
      end else begin
        logic [COL_W-1:0] ec;
        logic             el;
        string            et;
        ec = q_col.pop_front();
        el = q_last.pop_front();
        et = q_tag.pop_front();
        if (col_addr !== ec || beat_last !== el) begin
          n_bad++;
          $display("FAIL %s: actual col=%0d last=%0b expected col=%0d last=%0b",
                   et, col_addr, beat_last, ec, el);
        end
      end
    end
  end

  task automatic check_bit(string tag, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // Driver: queue the expected beats, then pulse start (and stop/poke as asked).
  task automatic run_burst(string tag, int col, int bl, bit ilv, bit wm, bit wr,
                           int stop_at, int poke_at);
    int  len;
    bit  page;
    int  nb;
    page = 0;
    case (bl)
      0: len = 1;
      1: len = 2;
      2: len = 4;
      3: len = 8;
      7: begin len = ilv ? 1 : PAGE; page = !ilv; end
      default: len = 1;
    endcase
    if (wm && wr) begin len = 1; page = 0; end
    nb = page ? stop_at + 1 : len;
    for (int k = 0; k < nb; k++) begin
      q_col.push_back(exp_col(col, len, ilv, page, k));
      q_last.push_back(k == nb - 1);
      q_tag.push_back(tag);
    end
    @(negedge clk);
    bl_code   = 3'(bl);
    burst_ilv = ilv;
    wr_single = wm;
    is_write  = wr;
    start_col = COL_W'(col);
    start     = 1'b1;
    @(negedge clk);
    for (int k = 1; k <= nb + 1; k++) begin
      start     = (k == poke_at);
      start_col = COL_W'(col + 77);
      stop      = (k == stop_at);
      @(negedge clk);
    end
    start = 1'b0;
    stop  = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bl_code = 3'b010; burst_ilv = 1'b0; wr_single = 1'b0;
    lat_code = 3'b010; start = 1'b0; start_col = '0; is_write = 1'b0; stop = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_bit("R1 valid after reset", beat_valid, 1'b0);
    check_bit("R1 last after reset", beat_last, 1'b0);

    run_burst("R3 len1",          5,   0, 0, 0, 0, -1, -1);
    run_burst("R3/R4 len2 asc",   5,   1, 0, 0, 0, -1, -1);
    run_burst("R3/R4 len4 asc",   6,   2, 0, 0, 0, -1, -1);
    run_burst("R2/R4 len8 asc",   499, 3, 0, 0, 0, -1, -1);
    run_burst("R5 len8 xor",      21,  3, 1, 0, 0, -1, -1);
    run_burst("R5 len4 xor",      14,  2, 1, 0, 0, -1, -1);
    run_burst("R6 page wrap",     510, 7, 0, 0, 0, 4, -1);
    run_burst("R6 page short",    3,   7, 0, 0, 0, 1, -1);

    for (int c = 4; c <= 6; c++) begin
      for (int t = 0; t < 2; t++) begin
        @(negedge clk);
        bl_code = 3'(c); burst_ilv = t[0];
        #1 check_bit("R7 cfg_err reserved length", cfg_err, 1'b1);
        run_burst("R7 reserved single", 40 + c, c, t[0], 0, 0, -1, -1);
      end
    end
    @(negedge clk);
    bl_code = 3'b111; burst_ilv = 1'b1;
    #1 check_bit("R7 cfg_err page with xor", cfg_err, 1'b1);
    burst_ilv = 1'b0;
    #1 check_bit("R7 cfg_err page ascending", cfg_err, 1'b0);
    run_burst("R7 page xor single", 60, 7, 1, 0, 0, -1, -1);

    run_burst("R8 single write",  9,   3, 0, 1, 1, -1, -1);
    run_burst("R8 read keeps len",9,   2, 0, 1, 0, -1, -1);
    run_burst("R8 write no wm",   9,   2, 1, 0, 1, -1, -1);
    run_burst("R8 page write wm", 200, 7, 0, 1, 1, -1, -1);

    for (int l = 0; l < 8; l++) begin
      @(negedge clk);
      bl_code = 3'b010; lat_code = 3'(l);
      #1 check_bit("R9 latency code check", cfg_err, (l == 2 || l == 3) ? 1'b0 : 1'b1);
    end
    lat_code = 3'b011;

    run_burst("R10 start while busy", 13, 2, 0, 0, 0, -1, 2);
    run_burst("R10 stop on fixed",    300, 3, 1, 0, 0, 3, -1);

    repeat (4) @(negedge clk);
    while (q_col.size() > 0) begin
      n_cmp++;
      n_bad++;
      $display("FAIL %s: actual missing beat expected col=%0d", q_tag[0], q_col[0]);
      void'(q_col.pop_front());
      void'(q_last.pop_front());
      void'(q_tag.pop_front());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule